// File: doc/BRIEF.md
# Translation Cache with Access Check

This block keeps a small, fully associative set of recently used translations from 20-bit virtual page numbers to 20-bit physical frame numbers. Each entry also carries three attributes: a user-access flag, a write-enable flag and a cache-inhibit flag. A lookup is combinational. In the cycle it is presented, the block answers hit or miss. On a hit it also returns the physical frame, the cache-inhibit attribute, and whether the access is allowed for the given privilege mode and access type.

When a lookup misses, an external page walker installs the translation through the fill port. Writing the translation base register flushes every entry. A single-page invalidate removes one entry, selected by its virtual page number. The table walk and any address-space tagging belong to surrounding logic.

Top module: `tlb_guard`

## Requirements
- R1: A lookup (`lkValid`=1) hits in the same cycle when a valid entry holds `lkVpn`. On a hit, `pfnOut` carries the stored frame and `noCache` carries the stored cache-inhibit flag. On a miss, or with no lookup, `hit`, `permitOk`, `noCache` and `pfnOut` are all zero.
- R2: `baseWrite`=1 makes any lookup in the same cycle miss, and at the next clock edge every entry becomes invalid.
- R3: `invValid`=1 removes only the entry whose page number equals `invVpn`; all other entries keep hitting. A lookup of `invVpn` in the same cycle misses.
- R4: In user mode (`lkUser`=1), an access is permitted only when the entry's user flag is 1, and a write additionally needs the write-enable flag to be 1.
- R5: In supervisor mode (`lkUser`=0), reads are always permitted. Writes are permitted when the write-enable flag is 1 or the user flag is 1.
- R6: A fill becomes visible to lookups from the next cycle on. A lookup of the same page in the cycle of its fill misses.
- R7: A fill whose page number already sits in a valid entry overwrites that entry, so there is never more than one entry for a page.
- R8: A new page goes to the lowest-numbered invalid entry. When all 8 entries are valid, it replaces the entry named by a round-robin pointer. The pointer starts at 0 after reset and advances by one, wrapping, only on such a replacement.
- R9: A fill presented in the same cycle as `baseWrite` or `invValid` is discarded, so no entry is written by it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lkValid | input | 1 | Lookup request |
| lkVpn | input | 20 | Virtual page number to translate |
| lkUser | input | 1 | 1 = user mode, 0 = supervisor mode |
| lkWrite | input | 1 | 1 = write access, 0 = read access |
| hit | output | 1 | Lookup found a usable translation |
| permitOk | output | 1 | Access allowed (only with hit) |
| pfnOut | output | 20 | Physical frame number on a hit |
| noCache | output | 1 | Cache-inhibit attribute on a hit |
| fillValid | input | 1 | Install a translation |
| fillVpn | input | 20 | Virtual page number of the fill |
| fillPfn | input | 20 | Physical frame number of the fill |
| fillUser | input | 1 | Fill attribute: user access allowed |
| fillWrite | input | 1 | Fill attribute: writable |
| fillNoCache | input | 1 | Fill attribute: cache inhibited |
| baseWrite | input | 1 | Translation base register written: flush all |
| invValid | input | 1 | Invalidate one page |
| invVpn | input | 20 | Virtual page number to invalidate |

## Verification
The assertions assume that reset is held low across at least one clock edge before any request arrives. They also assume that `lkUser` and `lkWrite` matter only while `lkValid` is high. The stimulus changes every input on the falling edge and returns all strobes to zero between operations. Flushes, invalidates and fills therefore overlap only in the cycles built to test their ordering. Every fill carries a defined page number, so the duplicate-free property can be checked against a clean table.

// File: rtl/tlbg_pkg.sv
package tlbg_pkg;
  localparam int VPN_W       = 20;
  localparam int PFN_W       = 20;
  localparam int TLB_ENTRIES = 8;
  localparam int IDX_W       = $clog2(TLB_ENTRIES);

  typedef struct packed {
    logic                   clearAll;
    logic [TLB_ENTRIES-1:0] dropMask;
    logic                   writeEn;
    logic [IDX_W-1:0]       writeIdx;
  } tlbStrobes_t;
endpackage

// File: rtl/tlbg_ctrl.sv
module tlbg_ctrl
  import tlbg_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   fillValid,
  input  logic                   invValid,
  input  logic                   baseWrite,
  input  logic [TLB_ENTRIES-1:0] fillMatch,
  input  logic [TLB_ENTRIES-1:0] invMatch,
  input  logic [TLB_ENTRIES-1:0] validVec,
  output tlbStrobes_t            strb
);
  logic [IDX_W-1:0] rrPtr;
  logic [IDX_W-1:0] freeIdx;
  logic [IDX_W-1:0] matchIdx;
  logic             anyFree;
  logic             anyMatch;
  logic             useVictim;

  // lowest-numbered free entry and the entry already holding the fill page
  always_comb begin
    freeIdx  = '0;
    anyFree  = 1'b0;
    matchIdx = '0;
    anyMatch = 1'b0;
    for (int i = TLB_ENTRIES - 1; i >= 0; i--) begin
      if (!validVec[i]) begin
        freeIdx = IDX_W'(i);
        anyFree = 1'b1;
      end
      if (fillMatch[i]) begin
        matchIdx = IDX_W'(i);
        anyMatch = 1'b1;
      end
    end
  end

  assign useVictim = !anyMatch && !anyFree;

  always_comb begin
    strb.clearAll = baseWrite;
    strb.dropMask = invValid ? invMatch : '0;
    strb.writeEn  = fillValid && !invValid && !baseWrite;
    strb.writeIdx = anyMatch ? matchIdx : (anyFree ? freeIdx : rrPtr);
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      rrPtr <= '0;
    else if (strb.writeEn && useVictim)
      rrPtr <= rrPtr + 1'b1;
  end

  // a new page never evicts a valid entry while a free one exists
  assert_no_evict_when_free_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.writeEn && !(|fillMatch) && !(&validVec)) |-> !validVec[strb.writeIdx]);
endmodule

// File: rtl/tlbg_store.sv
module tlbg_store
  import tlbg_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [VPN_W-1:0]       lkVpn,
  input  logic [VPN_W-1:0]       fillVpn,
  input  logic [PFN_W-1:0]       fillPfn,
  input  logic                   fillUser,
  input  logic                   fillWrite,
  input  logic                   fillNoCache,
  input  logic [VPN_W-1:0]       invVpn,
  input  tlbStrobes_t            strb,
  output logic [TLB_ENTRIES-1:0] lkMatch,
  output logic [TLB_ENTRIES-1:0] fillMatch,
  output logic [TLB_ENTRIES-1:0] invMatch,
  output logic [TLB_ENTRIES-1:0] validVec,
  output logic [PFN_W-1:0]       hitPfn,
  output logic                   hitUser,
  output logic                   hitWrite,
  output logic                   hitNoCache
);
  logic [TLB_ENTRIES-1:0] validQ;
  logic [VPN_W-1:0]       vpnQ   [TLB_ENTRIES];
  logic [PFN_W-1:0]       pfnQ   [TLB_ENTRIES];
  logic [TLB_ENTRIES-1:0] userQ;
  logic [TLB_ENTRIES-1:0] writeQ;
  logic [TLB_ENTRIES-1:0] ncQ;

  for (genvar g = 0; g < TLB_ENTRIES; g++) begin : gEntry
    logic selW;
    assign selW = strb.writeEn && (strb.writeIdx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rstN)                  validQ[g] <= 1'b0;
      else if (strb.clearAll)     validQ[g] <= 1'b0;
      else if (strb.dropMask[g])  validQ[g] <= 1'b0;
      else if (selW)              validQ[g] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (selW) begin
        vpnQ[g]   <= fillVpn;
        pfnQ[g]   <= fillPfn;
        userQ[g]  <= fillUser;
        writeQ[g] <= fillWrite;
        ncQ[g]    <= fillNoCache;
      end
    end

    assign lkMatch[g]   = validQ[g] && (vpnQ[g] == lkVpn);
    assign fillMatch[g] = validQ[g] && (vpnQ[g] == fillVpn);
    assign invMatch[g]  = validQ[g] && (vpnQ[g] == invVpn);
  end

  assign validVec = validQ;

  // one-hot select of the matching entry's payload
  always_comb begin
    hitPfn     = '0;
    hitUser    = 1'b0;
    hitWrite   = 1'b0;
    hitNoCache = 1'b0;
    for (int i = 0; i < TLB_ENTRIES; i++) begin
      hitPfn     = hitPfn | ({PFN_W{lkMatch[i]}} & pfnQ[i]);
      hitUser    = hitUser | (lkMatch[i] & userQ[i]);
      hitWrite   = hitWrite | (lkMatch[i] & writeQ[i]);
      hitNoCache = hitNoCache | (lkMatch[i] & ncQ[i]);
    end
  end

  assert_single_match_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(lkMatch) && $onehot0(fillMatch));

  assert_flush_empties_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearAll |=> (validVec == '0));
endmodule

// File: rtl/tlb_guard.sv
module tlb_guard
  import tlbg_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             lkValid,
  input  logic [VPN_W-1:0] lkVpn,
  input  logic             lkUser,
  input  logic             lkWrite,
  output logic             hit,
  output logic             permitOk,
  output logic [PFN_W-1:0] pfnOut,
  output logic             noCache,
  input  logic             fillValid,
  input  logic [VPN_W-1:0] fillVpn,
  input  logic [PFN_W-1:0] fillPfn,
  input  logic             fillUser,
  input  logic             fillWrite,
  input  logic             fillNoCache,
  input  logic             baseWrite,
  input  logic             invValid,
  input  logic [VPN_W-1:0] invVpn
);
  tlbStrobes_t            strb;
  logic [TLB_ENTRIES-1:0] lkMatch, fillMatch, invMatch, validVec;
  logic [PFN_W-1:0]       hitPfn;
  logic                   hitUser, hitWrite, hitNoCache;
  logic                   blocked, allowed;

  tlbg_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .fillValid(fillValid), .invValid(invValid),
    .baseWrite(baseWrite), .fillMatch(fillMatch), .invMatch(invMatch),
    .validVec(validVec), .strb(strb)
  );

  tlbg_store uStore (
    .clk(clk), .rstN(rstN), .lkVpn(lkVpn), .fillVpn(fillVpn), .fillPfn(fillPfn),
    .fillUser(fillUser), .fillWrite(fillWrite), .fillNoCache(fillNoCache),
    .invVpn(invVpn), .strb(strb), .lkMatch(lkMatch), .fillMatch(fillMatch),
    .invMatch(invMatch), .validVec(validVec), .hitPfn(hitPfn), .hitUser(hitUser),
    .hitWrite(hitWrite), .hitNoCache(hitNoCache)
  );

  // same-cycle maintenance on the looked-up page forces a miss
  assign blocked = baseWrite
                 || (invValid  && (invVpn  == lkVpn))
                 || (fillValid && (fillVpn == lkVpn));

  // user: needs user flag, writes also need write flag
  // supervisor: reads free, writes need write flag or user flag
  assign allowed = lkUser ? (hitUser && (!lkWrite || hitWrite))
                          : (!lkWrite || hitWrite || hitUser);

  assign hit      = lkValid && (|lkMatch) && !blocked;
  assign permitOk = hit && allowed;
  assign pfnOut   = hit ? hitPfn : '0;
  assign noCache  = hit && hitNoCache;

  assert_miss_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !hit |-> (pfnOut == '0 && !permitOk && !noCache));

  assert_flush_then_miss_R2: assert property (@(posedge clk) disable iff (!rstN)
    baseWrite |=> !hit);

  assert_user_flag_needed_R4: assert property (@(posedge clk) disable iff (!rstN)
    (hit && lkUser && !hitUser) |-> !permitOk);

  assert_super_read_ok_R5: assert property (@(posedge clk) disable iff (!rstN)
    (hit && !lkUser && !lkWrite) |-> permitOk);
endmodule

// File: tb/tb_tlb_guard.sv
module tb_tlb_guard;
  localparam int CLK_PERIOD = 10;
  localparam int VEC_N = 14;
  // {isFill, vpn, pfn, fUser, fWrite, fNc, usr, wr, expHit, expPermit, expNc}
  localparam logic [48:0] VECS [VEC_N] = '{
    {1'b1, 20'h00010, 20'hAAAAA, 3'b100, 2'b00, 3'b000},
    {1'b1, 20'h00020, 20'hBBBBB, 3'b110, 2'b00, 3'b000},
    {1'b1, 20'h00030, 20'hCCCCC, 3'b001, 2'b00, 3'b000},
    {1'b1, 20'h00040, 20'hDDDDD, 3'b010, 2'b00, 3'b000},
    {1'b0, 20'h00010, 20'hAAAAA, 3'b000, 2'b10, 3'b110},
    {1'b0, 20'h00010, 20'hAAAAA, 3'b000, 2'b11, 3'b100},
    {1'b0, 20'h00010, 20'hAAAAA, 3'b000, 2'b01, 3'b110},
    {1'b0, 20'h00020, 20'hBBBBB, 3'b000, 2'b11, 3'b110},
    {1'b0, 20'h00030, 20'hCCCCC, 3'b000, 2'b10, 3'b101},
    {1'b0, 20'h00030, 20'hCCCCC, 3'b000, 2'b00, 3'b111},
    {1'b0, 20'h00030, 20'hCCCCC, 3'b000, 2'b01, 3'b101},
    {1'b0, 20'h00040, 20'hDDDDD, 3'b000, 2'b01, 3'b110},
    {1'b0, 20'h00040, 20'hDDDDD, 3'b000, 2'b10, 3'b100},
    {1'b0, 20'h00050, 20'h00000, 3'b000, 2'b00, 3'b000}
  };

  logic clk = 1'b0;
  logic rstN;
  logic lkValid, lkUser, lkWrite;
  logic [19:0] lkVpn;
  logic hit, permitOk, noCache;
  logic [19:0] pfnOut;
  logic fillValid, fillUser, fillWrite, fillNoCache;
  logic [19:0] fillVpn, fillPfn;
  logic baseWrite, invValid;
  logic [19:0] invVpn;

  int total = 0;
  int failed = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlb_guard dut (
    .clk(clk), .rstN(rstN), .lkValid(lkValid), .lkVpn(lkVpn), .lkUser(lkUser),
    .lkWrite(lkWrite), .hit(hit), .permitOk(permitOk), .pfnOut(pfnOut),
    .noCache(noCache), .fillValid(fillValid), .fillVpn(fillVpn), .fillPfn(fillPfn),
    .fillUser(fillUser), .fillWrite(fillWrite), .fillNoCache(fillNoCache),
    .baseWrite(baseWrite), .invValid(invValid), .invVpn(invVpn)
  );

  task automatic expectVal(string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic checkOut(string tag, logic eHit, logic ePerm, logic [19:0] ePfn, logic eNc);
    expectVal(tag, "hit", 32'(hit), 32'(eHit));
    expectVal(tag, "permitOk", 32'(permitOk), 32'(ePerm));
    expectVal(tag, "pfnOut", 32'(pfnOut), 32'(ePfn));
    expectVal(tag, "noCache", 32'(noCache), 32'(eNc));
  endtask

  task automatic idleAll;
    lkValid = 0; lkVpn = '0; lkUser = 0; lkWrite = 0;
    fillValid = 0; fillVpn = '0; fillPfn = '0;
    fillUser = 0; fillWrite = 0; fillNoCache = 0;
    baseWrite = 0; invValid = 0; invVpn = '0;
  endtask

  task automatic doFill(logic [19:0] v, logic [19:0] p, logic u, logic w, logic n);
    @(negedge clk); idleAll;
    fillValid = 1; fillVpn = v; fillPfn = p; fillUser = u; fillWrite = w; fillNoCache = n;
    @(negedge clk); idleAll;
  endtask

  task automatic doInv(logic [19:0] v);
    @(negedge clk); idleAll;
    invValid = 1; invVpn = v;
    @(negedge clk); idleAll;
  endtask

  task automatic probe(string tag, logic [19:0] v, logic u, logic w,
                       logic eHit, logic ePerm, logic [19:0] ePfn, logic eNc);
    @(negedge clk); idleAll;
    lkValid = 1; lkVpn = v; lkUser = u; lkWrite = w;
    #1;
    checkOut(tag, eHit, ePerm, ePfn, eNc);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      failed++; total++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    idleAll;
    rstN = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;

    // reset state: empty table, everything misses (R1)
    probe("R1 reset", 20'h00000, 0, 0, 0, 0, 20'h0, 0);
    probe("R1 reset", 20'h00010, 1, 1, 0, 0, 20'h0, 0);

    // table walk: fills and permission checks (R1 R4 R5)
    for (int i = 0; i < VEC_N; i++) begin
      logic [48:0] v;
      v = VECS[i];
      if (v[48])
        doFill(v[47:28], v[27:8], v[7], v[6], v[5]);
      else
        probe($sformatf("R1/R4/R5 vec%0d", i), v[47:28], v[4], v[3], v[2], v[1], v[27:8], v[0]);
    end

    // R6: lookup in the fill cycle misses, visible on the next cycle
    @(negedge clk); idleAll;
    fillValid = 1; fillVpn = 20'h00060; fillPfn = 20'h66666; fillUser = 1; fillWrite = 1;
    lkValid = 1; lkVpn = 20'h00060;
    #1; checkOut("R6 same-cycle", 0, 0, 20'h0, 0);
    probe("R6 next-cycle", 20'h00060, 1, 1, 1, 1, 20'h66666, 0);

    // R7: refill of a present page overwrites it
    doFill(20'h00010, 20'h12345, 1, 1, 1);
    probe("R7 overwrite", 20'h00010, 1, 1, 1, 1, 20'h12345, 1);
    doInv(20'h00010);
    probe("R7 no duplicate", 20'h00010, 0, 0, 0, 0, 20'h0, 0);

    // R3: invalidate only the matching page
    @(negedge clk); idleAll;
    invValid = 1; invVpn = 20'h00020; lkValid = 1; lkVpn = 20'h00020;
    #1; checkOut("R3 same-cycle", 0, 0, 20'h0, 0);
    probe("R3 removed", 20'h00020, 0, 0, 0, 0, 20'h0, 0);
    probe("R3 others kept", 20'h00030, 0, 0, 1, 1, 20'hCCCCC, 1);
    probe("R3 others kept", 20'h00040, 0, 1, 1, 1, 20'hDDDDD, 0);

    // R9: fills dropped when colliding with invalidate or flush
    @(negedge clk); idleAll;
    fillValid = 1; fillVpn = 20'h00070; fillPfn = 20'h77777; invValid = 1; invVpn = 20'h00999;
    probe("R9 fill vs invalidate", 20'h00070, 0, 0, 0, 0, 20'h0, 0);
    probe("R9 inv other kept", 20'h00060, 0, 0, 1, 1, 20'h66666, 0);

    // R2: flush with same-cycle lookup, fill dropped as well (R9)
    @(negedge clk); idleAll;
    baseWrite = 1; lkValid = 1; lkVpn = 20'h00030;
    fillValid = 1; fillVpn = 20'h00080; fillPfn = 20'h88888;
    #1; checkOut("R2 same-cycle", 0, 0, 20'h0, 0);
    probe("R2 flushed", 20'h00030, 0, 0, 0, 0, 20'h0, 0);
    probe("R2 flushed", 20'h00060, 0, 0, 0, 0, 20'h0, 0);
    probe("R9 fill vs flush", 20'h00080, 0, 0, 0, 0, 20'h0, 0);

    // R8: fill to full, free slot preferred, then round-robin from 0
    for (int i = 0; i < 8; i++)
      doFill(20'h00100 + 20'(i), 20'h50000 + 20'(i), 0, 0, 0);
    doInv(20'h00103);
    doFill(20'h00300, 20'h53000, 0, 0, 0);
    probe("R8 free slot used", 20'h00100, 0, 0, 1, 1, 20'h50000, 0);
    probe("R8 free slot used", 20'h00300, 0, 0, 1, 1, 20'h53000, 0);
    doFill(20'h00200, 20'h52000, 0, 0, 0);
    probe("R8 victim 0", 20'h00100, 0, 0, 0, 0, 20'h0, 0);
    probe("R8 victim 0", 20'h00101, 0, 0, 1, 1, 20'h50001, 0);
    doFill(20'h00201, 20'h52001, 0, 0, 0);
    probe("R8 victim 1", 20'h00101, 0, 0, 0, 0, 20'h0, 0);
    probe("R8 victim 1", 20'h00102, 0, 0, 1, 1, 20'h50002, 0);
    probe("R8 new entry", 20'h00201, 0, 0, 1, 1, 20'h52001, 0);

    @(negedge clk); idleAll;
    done = 1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule